// File: doc/BRIEF.md
# Supply Rail Power Sequencer

This block orders the start-up and shutdown of four bias rails and the related system control outputs for a display power subsystem. It counts millisecond delays, which software sets through delay codes, and waits for ramp-done flags from the analog regulators. The bring-up order is fixed. The logic rail comes up first. The active-low system reset is released after it. Then come the first boost rail, the negative rail and the gate-high rail. Gate-voltage shaping is enabled last.

Every enabled rail is watched by two comparator flags. One reports the rail below 70 % of its target. The other reports the rail below 30 % of its target. The 70 % flag must persist for a programmable number of milliseconds before it trips. The 30 % flag trips after its synchroniser and no more. Either trip latches a global shutdown that only a power-on reset clears. When the input supply drops below its undervoltage threshold, every rail is switched off together. The reset and panel-discharge outputs each follow the threshold that is selected for them.

Top module: `rseq_top`

## Requirements
- R1: After power-on reset, every rail enable, soft-start strobe, reset output, shaping enable, panel-discharge output and the fault output is low.
- R2: The logic rail (rail_en bit 0) is enabled (min(code,15)+1) ms after vin_ok is seen high, so a code of zero advances on the first millisecond tick.
- R3: The reset output is released (code+1) ms after ramp_done bit 0 is seen high. Once released it stays high until vin_ok falls, a fault occurs, or the threshold picked by rst_sel (0 selects vin_ok, 1 selects det_ok) goes low. After that it stays low even when the threshold recovers.
- R4: The boost rail (rail_en bit 1) is enabled (min(code,75)+1) ms after the reset release.
- R5: The negative rail (rail_en bit 2) is enabled (min(code,35)+1) ms after the boost rail is enabled.
- R6: The gate-high rail (rail_en bit 3) stays off until ramp_done bit 2 is seen high and turns on within three cycles after it.
- R7: gs_en rises (min(code,35)+1) ms after ramp_done bit 3 is seen high and is low at all other times before that.
- R8: ss_start bit i is a single-cycle pulse in the first cycle that rail_en bit i is high. The bit order is 0 logic, 1 boost, 2 negative, 3 gate-high.
- R9: A low30 flag on a rail that is enabled and has its ramp_done set raises fault_off within five cycles.
- R10: A low70 flag on an armed rail raises fault_off only after it has been held for UV_MS ms without a break. Any deassertion restarts the count.
- R11: While fault_off is high, all rails, reset and gs_en are low, and xao_n goes low. This state persists whatever vin_ok does, until rst_n is asserted.
- R12: When vin_ok falls (no fault), all rails, reset and gs_en go low at the next edge. When vin_ok returns, the sequence starts again from the logic-rail delay.
- R13: xao_n is high one cycle after the threshold picked by xao_sel (0 vin_ok, 1 det_ok) is high with no fault, and low otherwise.
- R14: Comparator flags of a rail that is not enabled, or whose ramp_done is low, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low |
| vin_ok | input | 1 | Input above undervoltage lockout |
| det_ok | input | 1 | Input above the secondary detect threshold |
| ramp_done | input | 4 | Ramp finished, per rail |
| low70 | input | 4 | Rail below 70 % of target, per rail |
| low30 | input | 4 | Rail below 30 % of target, per rail |
| rst_sel | input | 1 | Reset threshold select |
| xao_sel | input | 1 | Panel-discharge threshold select |
| dly_logic | input | LOGIC_W | Logic rail delay code, ms |
| dly_rst | input | RST_W | Reset release delay code, ms |
| dly_boost | input | BOOST_W | Boost rail delay code, ms |
| dly_neg | input | NEG_W | Negative rail delay code, ms |
| dly_gs | input | GS_W | Gate-shaping delay code, ms |
| rail_en | output | 4 | Rail enables |
| ss_start | output | 4 | Soft-start start strobes |
| rst_out_n | output | 1 | System reset, active low |
| xao_n | output | 1 | Panel discharge, active low |
| gs_en | output | 1 | Gate-shaping enable |
| fault_off | output | 1 | Latched global shutdown |

## Verification
The bench builds the block with CLK_PER_MS set to 10 and UV_MS left at 50. A millisecond step then costs ten cycles, which keeps every delay code up to its clamp limit within a short run. It still leaves one tick of error ten cycles wide, far outside the check windows. The 50 ms undervoltage filter becomes 500 cycles, so the bench can test a long break-free hold, and also an interrupted hold that would trip early if the count were not restarted.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

   localparam int RAIL_N     = 4;
   localparam int RAIL_LOGIC = 0;
   localparam int RAIL_BOOST = 1;
   localparam int RAIL_NEG   = 2;
   localparam int RAIL_GH    = 3;

   typedef enum logic [3:0] {
      ST_OFF,
      ST_D_LOG,
      ST_W_LOG,
      ST_D_RST,
      ST_D_BST,
      ST_D_NEG,
      ST_W_NEG,
      ST_W_GH,
      ST_D_GS,
      ST_RUN,
      ST_FLT
   } seq_st_e;

   // Limit a delay code to its legal maximum.
   function automatic int clamp_code(input int code, input int lim);
      return (code > lim) ? lim : code;
   endfunction

   // Rails that are on while the sequencer sits in a given state.
   function automatic logic [RAIL_N-1:0] rails_on(input seq_st_e s);
      logic [RAIL_N-1:0] r;
      case (s)
         ST_W_LOG, ST_D_RST, ST_D_BST: r = 4'b0001;
         ST_D_NEG:                     r = 4'b0011;
         ST_W_NEG:                     r = 4'b0111;
         ST_W_GH, ST_D_GS, ST_RUN:     r = 4'b1111;
         default:                      r = 4'b0000;
      endcase
      return r;
   endfunction

   // States that count millisecond ticks.
   function automatic logic is_delay(input seq_st_e s);
      return (s == ST_D_LOG) || (s == ST_D_RST) || (s == ST_D_BST) ||
             (s == ST_D_NEG) || (s == ST_D_GS);
   endfunction

   // States in which a released reset may stay high.
   function automatic logic rst_keep(input seq_st_e s);
      return (s == ST_D_BST) || (s == ST_D_NEG) || (s == ST_W_NEG) ||
             (s == ST_W_GH)  || (s == ST_D_GS)  || (s == ST_RUN);
   endfunction

endpackage

// File: rtl/rseq_tick.sv
module rseq_tick #(
   parameter int CLK_PER_MS = 100000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   localparam int PW = (CLK_PER_MS > 2) ? $clog2(CLK_PER_MS) : 1;

   logic [PW-1:0] presc_q;

   assign tick = (presc_q == PW'(CLK_PER_MS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               presc_q <= '0;
      else if (restart || tick) presc_q <= '0;
      else                      presc_q <= presc_q + 1'b1;
   end
endmodule

// File: rtl/rseq_fault_mon.sv
module rseq_fault_mon #(
   parameter int SYNC_N = 2,
   parameter int UV_CYC = 5000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic low70,
   input  logic low30,
   output logic trip_short,
   output logic trip_uv
);
   localparam int UW = $clog2(UV_CYC + 1);

   logic [SYNC_N-1:0] s70_q;
   logic [SYNC_N-1:0] s30_q;
   logic [UW-1:0]     uv_cnt_q;
   logic              s70;
   logic              s30;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s70_q <= '0;
         s30_q <= '0;
      end else begin
         s70_q <= {s70_q[SYNC_N-2:0], low70};
         s30_q <= {s30_q[SYNC_N-2:0], low30};
      end
   end

   assign s70 = s70_q[SYNC_N-1];
   assign s30 = s30_q[SYNC_N-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     uv_cnt_q <= '0;
      else if (!arm || !s70)          uv_cnt_q <= '0;
      else if (uv_cnt_q != UW'(UV_CYC)) uv_cnt_q <= uv_cnt_q + 1'b1;
   end

   assign trip_short = arm && s30;
   assign trip_uv    = arm && (uv_cnt_q == UW'(UV_CYC));
endmodule

// File: rtl/rseq_fsm.sv
module rseq_fsm
   import rseq_pkg::*;
#(
   parameter int LOGIC_W   = 4,
   parameter int RST_W     = 4,
   parameter int BOOST_W   = 7,
   parameter int NEG_W     = 6,
   parameter int GS_W      = 6,
   parameter int BOOST_MAX = 75,
   parameter int NEG_MAX   = 35,
   parameter int GS_MAX    = 35
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               vin_ok,
   input  logic               rsel_ok,
   input  logic               log_done,
   input  logic               neg_done,
   input  logic               gh_done,
   input  logic               trip,
   input  logic               tick,
   input  logic [LOGIC_W-1:0] dly_logic,
   input  logic [RST_W-1:0]   dly_rst,
   input  logic [BOOST_W-1:0] dly_boost,
   input  logic [NEG_W-1:0]   dly_neg,
   input  logic [GS_W-1:0]    dly_gs,
   output logic               restart,
   output logic [RAIL_N-1:0]  rail_en,
   output logic               rst_out_n,
   output logic               gs_en,
   output logic               fault_off
);
   localparam int LOG_MAX = (1 << LOGIC_W) - 1;
   localparam int RST_MAX = (1 << RST_W) - 1;
   localparam int M1      = (LOG_MAX > RST_MAX) ? LOG_MAX : RST_MAX;
   localparam int M2      = (M1 > BOOST_MAX) ? M1 : BOOST_MAX;
   localparam int M3      = (M2 > NEG_MAX) ? M2 : NEG_MAX;
   localparam int DMAX    = (M3 > GS_MAX) ? M3 : GS_MAX;
   localparam int CW      = $clog2(DMAX + 1);

   seq_st_e           st_q, st_d;
   logic [CW-1:0]     dcnt_q;
   logic [CW-1:0]     code_ld;
   logic              expire;
   logic [RAIL_N-1:0] rail_q;
   logic              rst_q;
   logic              gs_q;
   logic              flt_q;

   assign expire = tick && (dcnt_q == '0) && is_delay(st_q);

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_OFF:   if (vin_ok)   st_d = ST_D_LOG;
         ST_D_LOG: if (expire)   st_d = ST_W_LOG;
         ST_W_LOG: if (log_done) st_d = ST_D_RST;
         ST_D_RST: if (expire)   st_d = ST_D_BST;
         ST_D_BST: if (expire)   st_d = ST_D_NEG;
         ST_D_NEG: if (expire)   st_d = ST_W_NEG;
         ST_W_NEG: if (neg_done) st_d = ST_W_GH;
         ST_W_GH:  if (gh_done)  st_d = ST_D_GS;
         ST_D_GS:  if (expire)   st_d = ST_RUN;
         default:                st_d = st_q;
      endcase
      if (st_q != ST_FLT) begin
         if (trip)         st_d = ST_FLT;
         else if (!vin_ok) st_d = ST_OFF;
      end
   end

   assign restart = (st_d != st_q);

   always_comb begin
      case (st_d)
         ST_D_LOG: code_ld = CW'(dly_logic);
         ST_D_RST: code_ld = CW'(dly_rst);
         ST_D_BST: code_ld = CW'(clamp_code(int'(dly_boost), BOOST_MAX));
         ST_D_NEG: code_ld = CW'(clamp_code(int'(dly_neg), NEG_MAX));
         ST_D_GS:  code_ld = CW'(clamp_code(int'(dly_gs), GS_MAX));
         default:  code_ld = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_OFF;
         dcnt_q <= '0;
         rail_q <= '0;
         rst_q  <= 1'b0;
         gs_q   <= 1'b0;
         flt_q  <= 1'b0;
      end else begin
         st_q <= st_d;
         if (restart)                      dcnt_q <= code_ld;
         else if (tick && dcnt_q != '0)    dcnt_q <= dcnt_q - 1'b1;
         rail_q <= rails_on(st_d);
         gs_q   <= (st_d == ST_RUN);
         flt_q  <= (st_d == ST_FLT);
         if (!rsel_ok || !rst_keep(st_d))
            rst_q <= 1'b0;
         else if (st_q == ST_D_RST && st_d == ST_D_BST)
            rst_q <= 1'b1;
      end
   end

   assign rail_en   = rail_q;
   assign rst_out_n = rst_q;
   assign gs_en     = gs_q;
   assign fault_off = flt_q;
endmodule

// File: rtl/rseq_top.sv
module rseq_top
   import rseq_pkg::*;
#(
   parameter int CLK_PER_MS = 100000,
   parameter int UV_MS      = 50,
   parameter int SYNC_N     = 2,
   parameter int LOGIC_W    = 4,
   parameter int RST_W      = 4,
   parameter int BOOST_W    = 7,
   parameter int NEG_W      = 6,
   parameter int GS_W       = 6,
   parameter int BOOST_MAX  = 75,
   parameter int NEG_MAX    = 35,
   parameter int GS_MAX     = 35
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               vin_ok,
   input  logic               det_ok,
   input  logic [3:0]         ramp_done,
   input  logic [3:0]         low70,
   input  logic [3:0]         low30,
   input  logic               rst_sel,
   input  logic               xao_sel,
   input  logic [LOGIC_W-1:0] dly_logic,
   input  logic [RST_W-1:0]   dly_rst,
   input  logic [BOOST_W-1:0] dly_boost,
   input  logic [NEG_W-1:0]   dly_neg,
   input  logic [GS_W-1:0]    dly_gs,
   output logic [3:0]         rail_en,
   output logic [3:0]         ss_start,
   output logic               rst_out_n,
   output logic               xao_n,
   output logic               gs_en,
   output logic               fault_off
);
   localparam int UV_CYC = UV_MS * CLK_PER_MS;

   if (CLK_PER_MS < 2) begin : g_bad_cpm
      $error("CLK_PER_MS must be at least 2");
   end
   if (SYNC_N < 2) begin : g_bad_sync
      $error("SYNC_N must be at least 2");
   end
   if (UV_MS < 1) begin : g_bad_uv
      $error("UV_MS must be at least 1");
   end
   if (BOOST_MAX >= (1 << BOOST_W) || NEG_MAX >= (1 << NEG_W) ||
       GS_MAX >= (1 << GS_W)) begin : g_bad_max
      $error("delay maximum does not fit its code width");
   end

   logic              tick;
   logic              restart;
   logic              rsel_ok;
   logic              trip;
   logic [RAIL_N-1:0] arm;
   logic [RAIL_N-1:0] trip_short;
   logic [RAIL_N-1:0] trip_uv;
   logic [RAIL_N-1:0] rail_prev_q;
   logic              xao_q;

   assign rsel_ok = rst_sel ? det_ok : vin_ok;
   assign arm     = rail_en & ramp_done;
   assign trip    = (|trip_short) || (|trip_uv);

   rseq_tick #(.CLK_PER_MS(CLK_PER_MS)) tick_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .tick    (tick)
   );

   for (genvar i = 0; i < RAIL_N; i++) begin : g_mon
      rseq_fault_mon #(.SYNC_N(SYNC_N), .UV_CYC(UV_CYC)) mon_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .arm        (arm[i]),
         .low70      (low70[i]),
         .low30      (low30[i]),
         .trip_short (trip_short[i]),
         .trip_uv    (trip_uv[i])
      );
   end

   rseq_fsm #(
      .LOGIC_W   (LOGIC_W),
      .RST_W     (RST_W),
      .BOOST_W   (BOOST_W),
      .NEG_W     (NEG_W),
      .GS_W      (GS_W),
      .BOOST_MAX (BOOST_MAX),
      .NEG_MAX   (NEG_MAX),
      .GS_MAX    (GS_MAX)
   ) fsm_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .vin_ok    (vin_ok),
      .rsel_ok   (rsel_ok),
      .log_done  (ramp_done[RAIL_LOGIC]),
      .neg_done  (ramp_done[RAIL_NEG]),
      .gh_done   (ramp_done[RAIL_GH]),
      .trip      (trip),
      .tick      (tick),
      .dly_logic (dly_logic),
      .dly_rst   (dly_rst),
      .dly_boost (dly_boost),
      .dly_neg   (dly_neg),
      .dly_gs    (dly_gs),
      .restart   (restart),
      .rail_en   (rail_en),
      .rst_out_n (rst_out_n),
      .gs_en     (gs_en),
      .fault_off (fault_off)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rail_prev_q <= '0;
         xao_q       <= 1'b0;
      end else begin
         rail_prev_q <= rail_en;
         xao_q       <= !fault_off && (xao_sel ? det_ok : vin_ok);
      end
   end

   assign ss_start = rail_en & ~rail_prev_q;
   assign xao_n    = xao_q;
endmodule

// File: rtl/rseq_chk.sv
module rseq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       vin_ok,
   input logic       det_ok,
   input logic       rst_sel,
   input logic [3:0] rail_en,
   input logic [3:0] ss_start,
   input logic       rst_out_n,
   input logic       xao_n,
   input logic       gs_en,
   input logic       fault_off
);
   a_r11_fault_outputs_off: assert property (@(posedge clk) disable iff (!rst_n)
      fault_off |-> (rail_en == 4'b0000) && !rst_out_n && !gs_en);

   a_r11_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      fault_off |=> fault_off);

   a_r11_fault_xao_low: assert property (@(posedge clk) disable iff (!rst_n)
      fault_off |=> !xao_n);

   a_r12_vin_drop_off: assert property (@(posedge clk) disable iff (!rst_n)
      !vin_ok |=> (rail_en == 4'b0000) && !gs_en && !rst_out_n);

   a_r3_reset_latched: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_out_n) |-> fault_off || $past(!vin_ok) ||
                           $past(rst_sel ? !det_ok : !vin_ok));

   a_r4_boost_after_logic: assert property (@(posedge clk) disable iff (!rst_n)
      rail_en[1] |-> rail_en[0]);

   a_r5_neg_after_boost: assert property (@(posedge clk) disable iff (!rst_n)
      rail_en[2] |-> rail_en[1]);

   a_r6_gh_after_neg: assert property (@(posedge clk) disable iff (!rst_n)
      rail_en[3] |-> rail_en[2]);

   a_r7_shaping_needs_gh: assert property (@(posedge clk) disable iff (!rst_n)
      gs_en |-> rail_en[3]);

   a_r8_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ss_start));

   a_r8_strobe_with_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (ss_start & ~rail_en) == 4'b0000);

   a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      (ss_start != 4'b0000) |=> ((ss_start & $past(ss_start)) == 4'b0000));
endmodule

bind rseq_top rseq_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .vin_ok    (vin_ok),
   .det_ok    (det_ok),
   .rst_sel   (rst_sel),
   .rail_en   (rail_en),
   .ss_start  (ss_start),
   .rst_out_n (rst_out_n),
   .xao_n     (xao_n),
   .gs_en     (gs_en),
   .fault_off (fault_off)
);

// File: tb/rseq_top_tb_top.sv
module rseq_top_tb_top;
   localparam int CPM    = 10;
   localparam int UV_MS  = 50;
   localparam int UV_CYC = CPM * UV_MS;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       vin_ok = 1'b0;
   logic       det_ok = 1'b0;
   logic [3:0] ramp_done = '0;
   logic [3:0] low70 = '0;
   logic [3:0] low30 = '0;
   logic       rst_sel = 1'b0;
   logic       xao_sel = 1'b0;
   logic [3:0] dly_logic = '0;
   logic [3:0] dly_rst = '0;
   logic [6:0] dly_boost = '0;
   logic [5:0] dly_neg = '0;
   logic [5:0] dly_gs = '0;
   logic [3:0] rail_en;
   logic [3:0] ss_start;
   logic       rst_out_n;
   logic       xao_n;
   logic       gs_en;
   logic       fault_off;

   int  n_chk = 0;
   int  n_err = 0;
   bit  done  = 1'b0;

   always #5 clk = ~clk;

   rseq_top #(.CLK_PER_MS(CPM), .UV_MS(UV_MS)) dut_i (
      .clk(clk), .rst_n(rst_n), .vin_ok(vin_ok), .det_ok(det_ok),
      .ramp_done(ramp_done), .low70(low70), .low30(low30),
      .rst_sel(rst_sel), .xao_sel(xao_sel), .dly_logic(dly_logic),
      .dly_rst(dly_rst), .dly_boost(dly_boost), .dly_neg(dly_neg),
      .dly_gs(dly_gs), .rail_en(rail_en), .ss_start(ss_start),
      .rst_out_n(rst_out_n), .xao_n(xao_n), .gs_en(gs_en),
      .fault_off(fault_off)
   );

   function automatic int exp_cyc(input int code, input int lim);
      return ((code > lim) ? lim : code) * CPM + CPM;
   endfunction

   function automatic logic sig(input int sel);
      case (sel)
         0: return rail_en[0];
         1: return rail_en[1];
         2: return rail_en[2];
         3: return rail_en[3];
         4: return rst_out_n;
         5: return gs_en;
         default: return fault_off;
      endcase
   endfunction

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   task automatic chk_win(input int sel, input int lo, input int hi, input string rq);
      int n = 0;
      while (!sig(sel) && n < hi + 5) begin
         @(negedge clk);
         n++;
      end
      chk(n >= lo && n <= hi, rq, n, (lo + hi) / 2);
   endtask

   task automatic por();
      rst_n = 1'b0; vin_ok = 1'b0; det_ok = 1'b0;
      ramp_done = '0; low70 = '0; low30 = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic run_up(input int dl, input int dr, input int db, input int dn, input int dg);
      dly_logic = 4'(dl); dly_rst = 4'(dr); dly_boost = 7'(db);
      dly_neg = 6'(dn); dly_gs = 6'(dg);
      vin_ok = 1'b1; det_ok = 1'b1;
      chk_win(0, exp_cyc(dl, 15) - 2, exp_cyc(dl, 15) + 2, "R2 logic rail delay");
      repeat (5) @(negedge clk);
      ramp_done[0] = 1'b1;
      chk_win(4, exp_cyc(dr, 15) - 2, exp_cyc(dr, 15) + 2, "R3 reset release delay");
      chk_win(1, exp_cyc(db, 75) - 2, exp_cyc(db, 75) + 2, "R4 boost rail delay");
      chk(ss_start == 4'b0010, "R8 boost strobe", ss_start, 2);
      @(negedge clk);
      chk(ss_start == 4'b0000, "R8 strobe single cycle", ss_start, 0);
      ramp_done[1] = 1'b1;
      chk_win(2, exp_cyc(dn, 35) - 2, exp_cyc(dn, 35) + 2, "R5 negative rail delay");
      repeat (7) @(negedge clk);
      chk(rail_en[3] == 1'b0, "R6 gate-high waits", rail_en[3], 0);
      ramp_done[2] = 1'b1;
      chk_win(3, 0, 3, "R6 gate-high start");
      ramp_done[3] = 1'b1;
      chk_win(5, exp_cyc(dg, 35) - 2, exp_cyc(dg, 35) + 2, "R7 shaping delay");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_err++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'd1729);
      por();
      // R1: reset state
      chk(rail_en == 4'b0000 && ss_start == 4'b0000, "R1 rails off", rail_en, 0);
      chk(!rst_out_n && !gs_en && !xao_n && !fault_off, "R1 controls low",
          {rst_out_n, gs_en, xao_n, fault_off}, 0);

      // R14: flags of unarmed rails ignored
      dly_logic = 4'd15;
      low30 = 4'b1111; low70 = 4'b1111;
      vin_ok = 1'b1; det_ok = 1'b1;
      repeat (700) @(negedge clk);
      chk(rail_en == 4'b0001 && !fault_off, "R14 unarmed flags ignored",
          {fault_off, rail_en}, 1);
      low30 = '0; low70 = '0;

      for (int r = 0; r < 6; r++) begin
         int dl, dr, db, dn, dg;
         por();
         rst_sel = (r == 1); xao_sel = 1'b0;
         dl = $urandom % 4; dr = $urandom % 16; db = $urandom % 8;
         dn = $urandom % 6; dg = $urandom % 6;
         if (r == 0) begin dl = 0; dr = 0; db = 0; dn = 0; dg = 0; end
         if (r == 3) begin dl = 15; dr = 15; db = 127; dn = 63; dg = 63; end
         run_up(dl, dr, db, dn, dg);
         chk(xao_n == 1'b1, "R13 xao high when ok", xao_n, 1);
         if (r == 0) begin
            vin_ok = 1'b0;
            @(negedge clk);
            chk(rail_en == 4'b0000 && !gs_en && !rst_out_n, "R12 all off on drop",
                {rst_out_n, gs_en, rail_en}, 0);
            ramp_done = '0;
            repeat (3) @(negedge clk);
            vin_ok = 1'b1;
            chk_win(0, exp_cyc(0, 15) - 2, exp_cyc(0, 15) + 2, "R12 restart");
         end else if (r == 1) begin
            det_ok = 1'b0;
            repeat (2) @(negedge clk);
            chk(!rst_out_n && rail_en == 4'b1111, "R3 reset follows det_ok",
                {rst_out_n, rail_en}, 15);
            chk(xao_n == 1'b1, "R13 xao on vin_ok", xao_n, 1);
            det_ok = 1'b1;
            repeat (20) @(negedge clk);
            chk(!rst_out_n, "R3 reset stays latched low", rst_out_n, 0);
            xao_sel = 1'b1; det_ok = 1'b0;
            repeat (2) @(negedge clk);
            chk(!xao_n, "R13 xao on det_ok low", xao_n, 0);
            det_ok = 1'b1;
            repeat (2) @(negedge clk);
            chk(xao_n, "R13 xao on det_ok high", xao_n, 1);
         end else if (r == 2) begin
            low30[2] = 1'b1;
            chk_win(6, 0, 5, "R9 short trips at once");
            chk(rail_en == 4'b0000 && !rst_out_n && !gs_en, "R11 outputs off",
                {rst_out_n, gs_en, rail_en}, 0);
            @(negedge clk);
            chk(!xao_n, "R11 xao low", xao_n, 0);
            low30 = '0; vin_ok = 1'b0;
            repeat (5) @(negedge clk);
            vin_ok = 1'b1;
            repeat (300) @(negedge clk);
            chk(fault_off && rail_en == 4'b0000, "R11 fault held",
                {fault_off, rail_en}, 16);
         end else if (r == 3) begin
            low70[1] = 1'b1;
            repeat (300) @(negedge clk);
            low70[1] = 1'b0;
            repeat (5) @(negedge clk);
            chk(!fault_off, "R10 short dip no fault", fault_off, 0);
            low70[1] = 1'b1;
            chk_win(6, UV_CYC + 1, UV_CYC + 5, "R10 undervoltage filter");
            low70 = '0;
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule